// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block takes a single PWM bit and produces the two gate-drive bits of a half-bridge: a high-side bit that follows the PWM level and a low-side bit that follows its inverse. Whenever the PWM level changes, the output that is switching off drops right away. The output that is switching on is held back by a programmable number of clock cycles, so the two switches are never on together.

A short filter in front of the sequencer discards input pulses narrower than a minimum width. A disable input forces both outputs low at once. The gating enable does the same when it is low. After either is released, the outputs come back only through a full dead-time interval, using whatever PWM level is present at that point. If the PWM level reverses while a turn-on is still waiting, that turn-on is cancelled and a one-cycle overlap flag is raised. A fresh dead-time interval then starts for the opposite output.

Top module: `hb_deadtime`

## Requirements
- R1: While rst_n is low, hs_out, ls_out and overlap_flag are 0. After reset is released with PWM low, ls_out rises on the D+1-th rising clock edge, where D is the effective dead time.
- R2: Polarity: in steady state with PWM at 1, hs_out=1 and ls_out=0. With PWM at 0, hs_out=0 and ls_out=1.
- R3: Take T as the first rising edge that samples a new PWM level, and MIN_W as the filter width (default 3). The output that is turning off goes low after edge T+MIN_W. The output that is turning on goes high after edge T+MIN_W+D.
- R4: hs_out and ls_out are never 1 in the same cycle. An output rises only from a cycle in which the other output was 0.
- R5: dt_cycles gives D directly in clock cycles (8 bits by default). A value of 0 is taken as D=1. The value 255 gives D=255.
- R6: dt_cycles is sampled only when a dead-time interval starts. A change made during a running interval does not alter that interval.
- R7: A PWM pulse that lasts fewer than MIN_W clock cycles leaves both outputs unchanged.
- R8: If the filtered PWM reverses while a turn-on is still waiting, that turn-on never happens. A new interval of D cycles starts for the opposite output, counted from the cycle after the reversal is filtered.
- R9: overlap_flag is high for exactly one cycle for each cancelled turn-on. It stays 0 on uninterrupted transitions, and both outputs are low while it is high.
- R10: disable_in=1 or gate_en=0 forces both outputs to 0 in the same cycle, without waiting for a clock edge. Take R as the first edge that samples the release. The output selected by the current PWM level then rises after edge R+D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | PWM command bit |
| dt_cycles | input | DT_W | Dead time in clock cycles (0 is taken as 1) |
| gate_en | input | 1 | Enable from the gating logic; 0 blocks both outputs |
| disable_in | input | 1 | 1 forces both outputs low immediately |
| hs_out | output | 1 | High-side drive |
| ls_out | output | 1 | Low-side drive |
| overlap_flag | output | 1 | One-cycle pulse when a pending turn-on is cancelled |

## Verification
For a PWM change first sampled at edge T, the turn-off is due at edge T+MIN_W and the turn-on at edge T+MIN_W+D. A release of disable or of the gating enable, first sampled at edge R, brings the selected output up at edge R+D. A reversal that arrives during the wait brings the opposite output up D edges after the cycle that follows the filtered reversal. Every scenario changes its inputs on a falling edge and counts the rising edges that follow, sampling on the next falling edge. Each result is therefore compared against an exact edge count, and a result that arrives one edge early or late is reported as a miscompare. The forcing low by disable is checked one time unit after the input changes, before any rising edge.

// File: rtl/hb_dt_pkg.sv
// Shared types for the dead-time generator.
// Assumes: nothing beyond IEEE 1800-2017.
package hb_dt_pkg;
    // Sequencer phase: reload interval, count dead time, drive a side.
    typedef enum logic [1:0] {
        PH_LOAD  = 2'd0,
        PH_WAIT  = 2'd1,
        PH_DRIVE = 2'd2
    } phase_t;
endpackage

// File: rtl/hb_glitch_filter.sv
// Minimum-width filter: the clean output takes a new level only after the
// raw input has held that level for MIN_W consecutive rising edges.
// Assumes: raw_in is synchronous to clk; MIN_W >= 1.
module hb_glitch_filter #(
    parameter int MIN_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    localparam int CW = (MIN_W > 1) ? $clog2(MIN_W) : 1;

    generate
        if (MIN_W == 1) begin : g_pass
            // Purpose: register the input with no width check.
            always_ff @(posedge clk) begin
                if (!rst_n) clean_out <= 1'b0;
                else        clean_out <= raw_in;
            end
        end else begin : g_filt
            logic [CW-1:0] run_q;
            // Purpose: count the edges the input differs, commit at MIN_W.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q     <= '0;
                    clean_out <= 1'b0;
                end else if (raw_in == clean_out) begin
                    run_q <= '0;
                end else if (run_q == CW'(MIN_W - 1)) begin
                    run_q     <= '0;
                    clean_out <= raw_in;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/hb_dt_counter.sv
// Dead-time down-counter: loads a cycle count (0 taken as 1) and flags
// expiry while its value is 1.
// Assumes: load has priority over counting.
module hb_dt_counter #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DT_W-1:0] load_val,
    output logic            expire
);
    logic [DT_W-1:0] cnt_q;
    logic [DT_W-1:0] eff_val;

    // Purpose: clamp a zero request to one cycle.
    always_comb eff_val = (load_val == '0) ? DT_W'(1) : load_val;

    // Purpose: load on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= eff_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    // Purpose: expiry indication for the sequencer.
    always_comb expire = (cnt_q == DT_W'(1));
endmodule

// File: rtl/hb_dt_sequencer.sv
// Output sequencer: tracks the side that the filtered PWM selects, clears
// both drives on each change, and turns the selected side on after the
// counter expires. Blocking, and a reversal during the wait, restart the
// dead-time interval.
// Assumes: load drives the counter in the same cycle it is raised.
module hb_dt_sequencer
    import hb_dt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_hi,
    input  logic blocked,
    input  logic expire,
    output logic load,
    output logic hs_q,
    output logic ls_q,
    output logic cancel_q
);
    phase_t phase_q;
    logic   side_q;
    logic   changed;

    // Purpose: detect a new target side.
    always_comb changed = (want_hi != side_q);

    // Purpose: start an interval on reload, or on any change of side.
    always_comb load = !blocked && ((phase_q == PH_LOAD) || changed);

    // Purpose: phase, side and drive registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_LOAD;
            side_q   <= 1'b0;
            hs_q     <= 1'b0;
            ls_q     <= 1'b0;
            cancel_q <= 1'b0;
        end else begin
            cancel_q <= 1'b0;
            if (blocked) begin
                phase_q <= PH_LOAD;
                hs_q    <= 1'b0;
                ls_q    <= 1'b0;
            end else begin
                case (phase_q)
                    PH_LOAD: begin
                        side_q  <= want_hi;
                        phase_q <= PH_WAIT;
                        hs_q    <= 1'b0;
                        ls_q    <= 1'b0;
                    end
                    PH_WAIT: begin
                        if (changed) begin
                            side_q   <= want_hi;
                            cancel_q <= 1'b1;
                        end else if (expire) begin
                            phase_q <= PH_DRIVE;
                            hs_q    <= side_q;
                            ls_q    <= !side_q;
                        end
                    end
                    default: begin
                        if (changed) begin
                            side_q  <= want_hi;
                            phase_q <= PH_WAIT;
                            hs_q    <= 1'b0;
                            ls_q    <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/hb_deadtime.sv
// Complementary PWM dead-time generator top: filter, dead-time counter,
// sequencer, and an immediate blocking gate on the outputs.
// Assumes: all inputs synchronous to clk; dt_cycles counts clock cycles.
module hb_deadtime #(
    parameter int DT_W  = 8,
    parameter int MIN_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_in,
    input  logic [DT_W-1:0] dt_cycles,
    input  logic            gate_en,
    input  logic            disable_in,
    output logic            hs_out,
    output logic            ls_out,
    output logic            overlap_flag
);
    logic pwm_clean;
    logic blocked;
    logic dt_load;
    logic dt_expire;
    logic hs_q;
    logic ls_q;

    // Purpose: either blocking source stops the drives.
    always_comb blocked = disable_in || !gate_en;

    hb_glitch_filter #(.MIN_W(MIN_W)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_in    (pwm_in),
        .clean_out (pwm_clean)
    );

    hb_dt_counter #(.DT_W(DT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dt_load),
        .load_val (dt_cycles),
        .expire   (dt_expire)
    );

    hb_dt_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .want_hi  (pwm_clean),
        .blocked  (blocked),
        .expire   (dt_expire),
        .load     (dt_load),
        .hs_q     (hs_q),
        .ls_q     (ls_q),
        .cancel_q (overlap_flag)
    );

    // Purpose: blocking forces the drives low without waiting for an edge.
    always_comb begin
        hs_out = hs_q && !blocked;
        ls_out = ls_q && !blocked;
    end
endmodule

// File: rtl/hb_deadtime_chk.sv
// Property checker for hb_deadtime, attached through bind.
// Assumes: synchronous active-low reset.
module hb_deadtime_chk (
    input logic clk,
    input logic rst_n,
    input logic disable_in,
    input logic hs_out,
    input logic ls_out,
    input logic overlap_flag
);
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_out && ls_out)); // R4
    AST_HS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_out) |-> $past(!ls_out)); // R4
    AST_LS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_out) |-> $past(!hs_out)); // R4
    AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_out) |-> !ls_out); // R3
    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_flag |-> (!hs_out && !ls_out)); // R9
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        disable_in |=> (!hs_out && !ls_out)); // R10
endmodule

bind hb_deadtime hb_deadtime_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .disable_in   (disable_in),
    .hs_out       (hs_out),
    .ls_out       (ls_out),
    .overlap_flag (overlap_flag)
);

// File: tb/hb_deadtime_bench.sv
// Directed bench for hb_deadtime: one task per scenario, exact edge counts.
module hb_deadtime_bench;
    localparam int DT_W  = 8;
    localparam int MIN_W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwm_in = 1'b0;
    logic [DT_W-1:0] dt_cycles = 8'd4;
    logic            gate_en = 1'b1;
    logic            disable_in = 1'b0;
    logic            hs_out, ls_out, overlap_flag;

    int vectors = 0;
    int errors  = 0;
    int flag_cnt = 0;
    bit done = 0;

    hb_deadtime #(.DT_W(DT_W), .MIN_W(MIN_W)) u_hb_deadtime (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dt_cycles(dt_cycles),
        .gate_en(gate_en), .disable_in(disable_in),
        .hs_out(hs_out), .ls_out(ls_out), .overlap_flag(overlap_flag)
    );

    always #2 clk = ~clk;

    // Continuous monitor: overlap check and flag counting (R4, R9).
    always @(negedge clk) begin
        if (rst_n) begin
            if (hs_out && ls_out) begin
                errors++;
                $display("FAIL R4: both outputs high, actual hs=%0b ls=%0b expected not both", hs_out, ls_out);
            end
            if (overlap_flag) flag_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drive a PWM level and count edges to turn-off and turn-on.
    task automatic edge_run(input logic lvl, input int chg_at, input int new_dt,
                            output int n_off, output int n_on);
        int n = 0;
        n_off = 0;
        n_on  = 0;
        pwm_in = lvl;
        for (int i = 0; i < 600; i++) begin
            tick();
            n++;
            if (n == chg_at) dt_cycles = new_dt[DT_W-1:0];
            if (n_off == 0 && (lvl ? !ls_out : !hs_out)) n_off = n;
            if (lvl ? hs_out : ls_out) begin
                n_on = n;
                break;
            end
        end
    endtask

    task automatic t_reset();
        int n = 0;
        repeat (3) tick();
        check("R1 reset hs", hs_out, 0);
        check("R1 reset ls", ls_out, 0);
        check("R1 reset flag", overlap_flag, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 50; i++) begin
            tick();
            n++;
            if (ls_out) break;
        end
        check("R1 startup edges to ls", n, 4 + 1);
        check("R2 low level hs", hs_out, 0);
    endtask

    task automatic t_polarity_timing();
        int off, on;
        dt_cycles = 8'd4;
        edge_run(1'b1, 0, 0, off, on);
        check("R3 rise turn-off edge", off, MIN_W + 1);
        check("R3 rise turn-on edge", on, MIN_W + 4 + 1);
        check("R2 high level ls", ls_out, 0);
        edge_run(1'b0, 0, 0, off, on);
        check("R3 fall turn-off edge", off, MIN_W + 1);
        check("R3 fall turn-on edge", on, MIN_W + 4 + 1);
        check("R2 low level hs", hs_out, 0);
    endtask

    task automatic t_dt_limits();
        int off, on;
        dt_cycles = 8'd0;
        edge_run(1'b1, 0, 0, off, on);
        check("R5 zero dead time edge", on, MIN_W + 1 + 1);
        dt_cycles = 8'd255;
        edge_run(1'b0, 0, 0, off, on);
        check("R5 max dead time edge", on, MIN_W + 255 + 1);
    endtask

    task automatic t_dt_sampled();
        int off, on;
        dt_cycles = 8'd4;
        edge_run(1'b1, MIN_W + 2, 50, off, on);
        check("R6 mid-interval change ignored", on, MIN_W + 4 + 1);
        dt_cycles = 8'd4;
    endtask

    task automatic t_glitch();
        int bad = 0;
        pwm_in = 1'b0;
        repeat (MIN_W - 1) tick();
        pwm_in = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (!hs_out || ls_out) bad++;
        end
        check("R7 short pulse suppressed", bad, 0);
    endtask

    task automatic t_reversal();
        int f0, n = 0, ls_seen = 0;
        dt_cycles = 8'd20;
        f0 = flag_cnt;
        pwm_in = 1'b0;
        repeat (8) begin tick(); n++; end
        pwm_in = 1'b1;
        for (int i = 0; i < 100; i++) begin
            tick();
            n++;
            if (ls_out) ls_seen++;
            if (hs_out) break;
        end
        check("R8 cancelled side stayed low", ls_seen, 0);
        check("R8 restart edge", n, 12 + 20);
        check("R9 one flag pulse", flag_cnt - f0, 1);
        dt_cycles = 8'd4;
    endtask

    task automatic t_flag_quiet();
        int off, on, f0;
        f0 = flag_cnt;
        edge_run(1'b0, 0, 0, off, on);
        edge_run(1'b1, 0, 0, off, on);
        check("R9 no flag on clean edges", flag_cnt - f0, 0);
    endtask

    task automatic t_block(input bit use_dis);
        int n = 0;
        if (use_dis) disable_in = 1'b1; else gate_en = 1'b0;
        #1;
        check("R10 immediate hs low", hs_out, 0);
        check("R10 immediate ls low", ls_out, 0);
        repeat (3) tick();
        pwm_in = 1'b0;
        repeat (6) tick();
        check("R10 held low while blocked", hs_out | ls_out, 0);
        if (use_dis) disable_in = 1'b0; else gate_en = 1'b1;
        for (int i = 0; i < 50; i++) begin
            tick();
            n++;
            if (ls_out) break;
        end
        check("R10 resume edge", n, 4 + 1);
        check("R10 resume polarity hs", hs_out, 0);
        pwm_in = 1'b1;
        repeat (MIN_W + 6) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_polarity_timing();
        t_dt_limits();
        t_dt_sampled();
        t_glitch();
        t_reversal();
        t_flag_quiet();
        t_block(1'b1);
        t_block(1'b0);
        finish_run();
    end
endmodule